// File: doc/BRIEF.md
# DRAM refresh and initialisation scheduler

This block keeps an asynchronous DRAM alive. After reset it stays quiet for a programmable power-up pause. It then runs a fixed number of warm-up strobe cycles, each of which contains a row-strobe pulse. Only after these does it declare the memory usable. From then on an interval timer produces one refresh request per period. The period is chosen so that all rows are visited inside the retention window; with the defaults, 256 rows in 4 ms gives about 15.6 µs, or 1560 clocks at 100 MHz.

Each refresh is negotiated with the access controller through a request/grant pair. The block drives its own row and column strobes, which an external multiplexer merges with the access controller's strobes. It also raises a busy flag whenever it owns the memory. Two refresh styles are selectable per cycle. In column-first refresh the memory's internal counter picks the row, so no address is needed. In row-only refresh the block drives a row address from its own wrapping counter.

Refreshes that cannot be served at once build up a small backlog. Crossing a threshold raises an urgent flag. A tick that arrives with the backlog already full sets a sticky error. A resume pulse, used after the clock has been stopped longer than the retention window, replays the warm-up sequence.

Top module: `dram_refresh_sched`

## Requirements
- R1: For `PAUSE_CLKS` clocks after reset is released, both column strobes and the row strobe stay high. The first warm-up strobe appears on clock `PAUSE_CLKS+1`.
- R2: After the pause, exactly `WARMUP_CYCLES` strobe cycles with a row-strobe pulse are run. `busy_o` then drops and normal operation starts.
- R3: In normal operation a refresh tick is due every `REFRESH_PERIOD` clocks. The first tick comes `REFRESH_PERIOD` clocks after `busy_o` drops, and each tick adds one pending refresh.
- R4: In column-first mode (`row_mode_i`=0), `cas_lo_n_o` goes low `T_CSR` clocks before the row strobe falls. It stays low for the first `T_CHR` of the `T_RAS` row-strobe-low clocks. A precharge of `T_RP` clocks with both strobes high follows. `cas_hi_n_o` stays high at all times.
- R5: In row-only mode (`row_mode_i`=1), the row strobe is low for `T_RAS` clocks and then high for `T_RP` clocks, with both column strobes high. `row_addr_o` holds the row throughout. The counter advances by one, wrapping from `ROWS-1` to 0, when the cycle ends. A column-first cycle leaves `row_addr_o` unchanged.
- R6: `req_o` is high only in normal operation, with at least one refresh pending, no strobe cycle in progress and no resume pending. A cycle starts on the clock edge where `req_o` and `grant_i` are both high. `grant_i` has no effect while `req_o` is low.
- R7: `busy_o` is high during the pause, the warm-up, any refresh strobe cycle, and while a resume is pending.
- R8: `urgent_o` is high exactly when the pending count is at least `URGENT_LEVEL`. Each completed refresh lowers the count by one.
- R9: The pending count saturates at `BACKLOG_MAX`. A tick arriving at that level sets `overflow_o`, which stays set until reset.
- R10: A one-clock `resume_i` pulse in normal operation raises `busy_o` on the next clock. Once any running cycle finishes, the block replays `WARMUP_CYCLES` strobe cycles, keeping `req_o` low, and then returns to normal operation.
- R11: While reset is asserted, all strobes are high, `busy_o` is 1, and `req_o`, `urgent_o`, `overflow_o` and `row_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resume_i | input | 1 | Pulse after a long clock stop; replays the warm-up |
| row_mode_i | input | 1 | 1 selects row-only refresh, 0 column-first refresh; sampled when a cycle starts |
| grant_i | input | 1 | Access controller hands the memory to this block |
| req_o | output | 1 | A refresh is pending and the block is ready to run it |
| urgent_o | output | 1 | Pending count has reached the urgent level |
| overflow_o | output | 1 | Sticky: a refresh tick was lost |
| busy_o | output | 1 | Block owns or is preparing the memory |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_lo_n_o | output | 1 | Lower column strobe, active low |
| cas_hi_n_o | output | 1 | Upper column strobe, active low (held high) |
| row_addr_o | output | $clog2(ROWS) | Row address for row-only refresh |

## Verification
A grant sampled at an edge changes the strobes on that same edge. The first sample after it is therefore strobe-pattern index 0, and the bench compares one sample per clock against a pattern built from the timing parameters. The counter update and the fall of `busy_o` appear on the sample after the final precharge clock. A refresh tick raises `req_o` and `urgent_o` on the sample right after its edge. The bench therefore checks `urgent_o` one clock before and exactly on the tick. It checks the gap to the first request as exactly `REFRESH_PERIOD` samples after `busy_o` falls. It checks the first warm-up strobe at sample `PAUSE_CLKS+1` after reset release. `resume_i` shows on `busy_o` one sample after the edge that takes it.

// File: rtl/drs_pkg.sv
package drs_pkg;
    typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_ACT, SQ_PRE} seq_st_e;
    typedef enum logic [1:0] {MN_PAUSE, MN_WARM, MN_RUN} main_st_e;
endpackage

// File: rtl/drs_tick_gen.sv
module drs_tick_gen #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int W = $clog2(PERIOD);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tk_t;

    tk_t t_d, t_q;

    assign tick_o = run_i && (t_q.cnt == W'(PERIOD - 1));

    always_comb begin
        t_d = t_q;
        if (!run_i)      t_d.cnt = '0;
        else if (tick_o) t_d.cnt = '0;
        else             t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R3: ticks never come back to back
    p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/drs_backlog.sv
module drs_backlog #(
    parameter int MAX = 7,
    parameter int URG = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic dec_i,
    output logic pending_o,
    output logic urgent_o,
    output logic ovf_o
);
    localparam int W = $clog2(MAX + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } bl_t;

    bl_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (tick_i && !dec_i) begin
            if (b_q.cnt == W'(MAX)) b_d.ovf = 1'b1;
            else                    b_d.cnt = b_q.cnt + 1'b1;
        end else if (dec_i && !tick_i && b_q.cnt != '0) begin
            b_d.cnt = b_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign pending_o = (b_q.cnt != '0);
    assign urgent_o  = (b_q.cnt >= W'(URG));
    assign ovf_o     = b_q.ovf;

    // R9: a lost tick is flagged and the flag holds
    p_ovf_on_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !dec_i && b_q.cnt == W'(MAX)) |=> ovf_o);
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
endmodule

// File: rtl/drs_strobe_seq.sv
module drs_strobe_seq
    import drs_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_RAS = 4,
    parameter int T_RP  = 3,
    parameter int T_CHR = 1,
    parameter int ROWS  = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      row_mode_i,
    output logic                      ras_n_o,
    output logic                      cas_n_o,
    output logic [$clog2(ROWS)-1:0]   row_o,
    output logic                      busy_o,
    output logic                      done_o
);
    localparam int TM1  = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int TMAX = (TM1 > T_RP) ? TM1 : T_RP;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(ROWS);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          rowm;
        logic [RW-1:0] row;
    } sq_t;

    sq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: if (start_i) begin
                s_d.rowm = row_mode_i;
                s_d.cnt  = '0;
                s_d.st   = row_mode_i ? SQ_ACT : SQ_SETUP;
            end
            SQ_SETUP: if (s_q.cnt == CW'(T_CSR - 1)) begin
                s_d.st  = SQ_ACT;
                s_d.cnt = '0;
            end else s_d.cnt = s_q.cnt + 1'b1;
            SQ_ACT: if (s_q.cnt == CW'(T_RAS - 1)) begin
                s_d.st  = SQ_PRE;
                s_d.cnt = '0;
            end else s_d.cnt = s_q.cnt + 1'b1;
            SQ_PRE: if (s_q.cnt == CW'(T_RP - 1)) begin
                s_d.st  = SQ_IDLE;
                s_d.cnt = '0;
                done_o  = 1'b1;
                if (s_q.rowm)
                    s_d.row = (s_q.row == RW'(ROWS - 1)) ? '0 : s_q.row + 1'b1;
            end else s_d.cnt = s_q.cnt + 1'b1;
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, cnt: '0, rowm: 1'b0, row: '0};
        else        s_q <= s_d;
    end

    assign ras_n_o = (s_q.st != SQ_ACT);
    assign cas_n_o = !(!s_q.rowm && (s_q.st == SQ_SETUP ||
                       (s_q.st == SQ_ACT && s_q.cnt < CW'(T_CHR))));
    assign row_o   = s_q.row;
    assign busy_o  = (s_q.st != SQ_IDLE);

    // Run-length counters of the row strobe, used only by the checks below
    logic [CW-1:0] lo_run_q, hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run_q <= '0;
            hi_run_q <= CW'(T_RP);
        end else if (ras_n_o) begin
            lo_run_q <= '0;
            hi_run_q <= (hi_run_q >= CW'(T_RP)) ? hi_run_q : hi_run_q + 1'b1;
        end else begin
            hi_run_q <= '0;
            lo_run_q <= (lo_run_q >= CW'(TMAX)) ? lo_run_q : lo_run_q + 1'b1;
        end
    end

    p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (lo_run_q == CW'(T_RAS)));
    p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (hi_run_q >= CW'(T_RP)));
    p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));
    p_rowonly_cas_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && s_q.rowm) |-> cas_n_o);
    p_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && s_q.rowm) |=> $stable(row_o));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import drs_pkg::*;
#(
    parameter int PAUSE_CLKS     = 20000,
    parameter int WARMUP_CYCLES  = 8,
    parameter int REFRESH_PERIOD = 1560,
    parameter int ROWS           = 256,
    parameter int T_CSR          = 1,
    parameter int T_RAS          = 4,
    parameter int T_RP           = 3,
    parameter int T_CHR          = 1,
    parameter int BACKLOG_MAX    = 7,
    parameter int URGENT_LEVEL   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    resume_i,
    input  logic                    row_mode_i,
    input  logic                    grant_i,
    output logic                    req_o,
    output logic                    urgent_o,
    output logic                    overflow_o,
    output logic                    busy_o,
    output logic                    ras_n_o,
    output logic                    cas_lo_n_o,
    output logic                    cas_hi_n_o,
    output logic [$clog2(ROWS)-1:0] row_addr_o
);
    localparam int PW = $clog2(PAUSE_CLKS + 1);
    localparam int WW = $clog2(WARMUP_CYCLES + 1);

    typedef struct packed {
        main_st_e      st;
        logic [PW-1:0] pcnt;
        logic [WW-1:0] wcnt;
        logic          pend;
    } mn_t;

    mn_t  m_d, m_q;
    logic seq_start, seq_busy, seq_done, tick, pending, run;

    assign run   = (m_q.st == MN_RUN);
    assign req_o = run && pending && !seq_busy && !m_q.pend;

    always_comb begin
        m_d       = m_q;
        seq_start = 1'b0;
        unique case (m_q.st)
            MN_PAUSE: if (m_q.pcnt == PW'(PAUSE_CLKS - 1)) begin
                m_d.st   = MN_WARM;
                m_d.wcnt = '0;
            end else m_d.pcnt = m_q.pcnt + 1'b1;
            MN_WARM: begin
                seq_start = !seq_busy;
                if (seq_done) begin
                    if (m_q.wcnt == WW'(WARMUP_CYCLES - 1)) m_d.st = MN_RUN;
                    else m_d.wcnt = m_q.wcnt + 1'b1;
                end
            end
            MN_RUN: begin
                seq_start = req_o && grant_i;
                if (resume_i) m_d.pend = 1'b1;
                if (m_q.pend && !seq_busy) begin
                    m_d.st   = MN_WARM;
                    m_d.wcnt = '0;
                    m_d.pend = 1'b0;
                end
            end
            default: m_d.st = MN_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '{st: MN_PAUSE, pcnt: '0, wcnt: '0, pend: 1'b0};
        else        m_q <= m_d;
    end

    drs_tick_gen #(.PERIOD(REFRESH_PERIOD)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_o(tick)
    );

    drs_backlog #(.MAX(BACKLOG_MAX), .URG(URGENT_LEVEL)) u_backlog (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dec_i(seq_done && run),
        .pending_o(pending), .urgent_o(urgent_o), .ovf_o(overflow_o)
    );

    drs_strobe_seq #(
        .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_CHR(T_CHR), .ROWS(ROWS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(seq_start), .row_mode_i(row_mode_i),
        .ras_n_o(ras_n_o), .cas_n_o(cas_lo_n_o), .row_o(row_addr_o),
        .busy_o(seq_busy), .done_o(seq_done)
    );

    assign cas_hi_n_o = 1'b1;
    assign busy_o     = !run || seq_busy || m_q.pend;

    p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st == MN_PAUSE) |-> (ras_n_o && cas_lo_n_o));
    p_busy_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o || !cas_lo_n_o) |-> busy_o);
    p_req_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !busy_o);
    p_grant_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && grant_i) |=> (!ras_n_o || !cas_lo_n_o));
    p_resume_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_i && run) |=> busy_o);
endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
    localparam int PAUSE = 20;
    localparam int WARM  = 3;
    localparam int PER   = 40;
    localparam int ROWS  = 8;
    localparam int TCSR  = 2;
    localparam int TRAS  = 4;
    localparam int TRP   = 3;
    localparam int TCHR  = 2;
    localparam int BMAX  = 3;
    localparam int URG   = 2;

    // bit 3: row-only mode, bits 2:0: row expected on row_addr_o before the cycle
    localparam logic [3:0] VEC [12] = '{
        4'b0_000, 4'b1_000, 4'b1_001, 4'b0_010, 4'b1_010, 4'b1_011,
        4'b1_100, 4'b1_101, 4'b1_110, 4'b1_111, 4'b1_000, 4'b0_001};

    logic clk = 1'b0;
    logic rst_n = 1'b0, resume = 1'b0, row_mode = 1'b0, grant = 1'b0;
    logic req, urgent, ovf, busy, ras_n, cas_lo_n, cas_hi_n;
    logic [2:0] row;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CLKS(PAUSE), .WARMUP_CYCLES(WARM), .REFRESH_PERIOD(PER), .ROWS(ROWS),
        .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .T_CHR(TCHR),
        .BACKLOG_MAX(BMAX), .URGENT_LEVEL(URG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .resume_i(resume), .row_mode_i(row_mode),
        .grant_i(grant), .req_o(req), .urgent_o(urgent), .overflow_o(ovf),
        .busy_o(busy), .ras_n_o(ras_n), .cas_lo_n_o(cas_lo_n), .cas_hi_n_o(cas_hi_n),
        .row_addr_o(row)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_req(output bit seen);
        seen = 0;
        for (int c = 0; c < 3 * PER; c++) begin
            if (req) begin
                seen = 1;
                break;
            end
            step();
        end
    endtask

    task automatic do_refresh();
        bit s;
        wait_req(s);
        grant = 1'b1;
        step();
        grant = 1'b0;
        repeat (TCSR + TRAS + TRP) step();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit seen, quiet, rq;
        int falls, n;
        logic prev;

        // R11: state held under reset
        repeat (3) step();
        check(ras_n && cas_lo_n && cas_hi_n && busy && !req && !urgent && !ovf && row == 3'd0,
              "R11", "reset outputs", int'({ras_n, cas_lo_n, busy, req, urgent, ovf}), 6'b111000);
        rst_n = 1'b1;

        // R1: quiet pause, first strobe on clock PAUSE+1
        quiet = 1;
        for (int i = 1; i <= PAUSE; i++) begin
            step();
            if (!ras_n || !cas_lo_n) quiet = 0;
        end
        check(quiet, "R1", "strobe during pause", 0, 1);
        step();
        check(!cas_lo_n && ras_n, "R1", "first warm-up strobe", int'({ras_n, cas_lo_n}), 2'b10);

        // R2 / R7: warm-up count, busy held, then released
        falls = 0; prev = ras_n; rq = 0; n = 0;
        while (busy && n < 400) begin
            step();
            n++;
            if (prev && !ras_n) falls++;
            if (req) rq = 1;
            prev = ras_n;
        end
        check(falls == WARM, "R2", "warm-up row strobes", falls, WARM);
        check(!busy && !rq, "R7", "busy over warm-up", int'({busy, rq}), 0);

        // R3: first request one period after busy drops
        n = 0;
        for (int c = 1; c <= 2 * PER; c++) begin
            step();
            if (req) begin
                n = c;
                break;
            end
        end
        check(n == PER, "R3", "first request delay", n, PER);

        // Table of refresh cycles (R4 column-first, R5 row-only, R6 handshake)
        for (int i = 0; i < 12; i++) begin
            bit m;
            int r, tot, bad, act, exp;
            m = VEC[i][3];
            r = int'(VEC[i][2:0]);
            row_mode = m;
            wait_req(seen);
            check(seen, "R6", "request raised", int'(seen), 1);
            grant = 1'b1;
            step();
            grant = 1'b0;
            tot = (m ? 0 : TCSR) + TRAS + TRP;
            bad = -1; act = 0; exp = 0;
            for (int k = 0; k <= tot; k++) begin
                int er, ec, eb, ew;
                if (!m) begin
                    if (k < TCSR)             begin er = 1; ec = 0; end
                    else if (k < TCSR + TRAS) begin er = 0; ec = (k - TCSR < TCHR) ? 0 : 1; end
                    else                      begin er = 1; ec = 1; end
                end else begin
                    if (k < TRAS) begin er = 0; ec = 1; end
                    else          begin er = 1; ec = 1; end
                end
                eb = (k < tot) ? 1 : 0;
                ew = (k == tot && m) ? (r + 1) % ROWS : r;
                if (bad < 0 && ({ras_n, cas_lo_n, cas_hi_n, busy} != {er[0], ec[0], 1'b1, eb[0]}
                                || int'(row) != ew)) begin
                    bad = k;
                    act = int'({ras_n, cas_lo_n, cas_hi_n, busy, row});
                    exp = int'({er[0], ec[0], 1'b1, eb[0], ew[2:0]});
                end
                if (k < tot) step();
            end
            check(bad < 0, m ? "R5" : "R4", $sformatf("pattern entry %0d at clock %0d", i, bad), act, exp);
        end

        // R6: grant without request does nothing
        grant = 1'b1;
        quiet = 1;
        repeat (10) begin
            step();
            if (!ras_n || !cas_lo_n || req) quiet = 0;
        end
        grant = 1'b0;
        check(quiet, "R6", "grant while idle", 0, 1);

        // R10: resume replays the warm-up
        row_mode = 1'b0;
        step();
        resume = 1'b1;
        step();
        resume = 1'b0;
        check(busy, "R10", "busy after resume", int'(busy), 1);
        falls = 0; prev = ras_n; rq = 0; n = 0;
        while (busy && n < 400) begin
            step();
            n++;
            if (prev && !ras_n) falls++;
            if (req) rq = 1;
            prev = ras_n;
        end
        check(falls == WARM, "R10", "replayed warm-up strobes", falls, WARM);
        check(!rq, "R10", "request during replay", int'(rq), 0);
        n = 0;
        for (int c = 1; c <= 2 * PER; c++) begin
            step();
            if (req) begin
                n = c;
                break;
            end
        end
        check(n == PER, "R3", "request delay after replay", n, PER);

        // R8 / R9: backlog growth with no grants
        check(!urgent, "R8", "urgent at one pending", int'(urgent), 0);
        repeat (PER - 1) step();
        check(!urgent, "R3", "no tick before period", int'(urgent), 0);
        step();
        check(urgent && req, "R8", "urgent at two pending", int'({urgent, req}), 3);
        repeat (PER) step();
        check(!ovf, "R9", "full backlog without loss", int'(ovf), 0);
        repeat (PER) step();
        check(ovf, "R9", "tick lost at full backlog", int'(ovf), 1);
        do_refresh();
        do_refresh();
        check(!urgent, "R8", "urgent after two refreshes", int'(urgent), 0);
        check(ovf, "R9", "overflow sticky", int'(ovf), 1);

        // R11: reset clears the sticky flag
        rst_n = 1'b0;
        step();
        step();
        check(!ovf && !urgent && busy && row == 3'd0, "R11", "second reset",
              int'({ovf, urgent, busy}), 3'b001);
        report();
    end
endmodule